// File: doc/BRIEF.md
# Flash Wait-State Access Controller

This block sits between an instruction fetch path and a slow on-chip instruction memory. A 32-bit control word, written and read over a simple register port, sets how many wait states each memory read takes, whether single-cycle half-clock access is used, and whether the lookahead path is enabled. A separate read-only flag shows whether the lookahead path is actually in effect. It follows the enable flag, but only between accesses.

On the memory side the block takes one read request at a time. It holds the request for the programmed number of wait cycles and then returns the word with a one-cycle valid strobe. The wait-state field is meant to be chosen from the system clock frequency: 0 wait states up to 24 MHz, 1 up to 48 MHz and 2 up to 72 MHz. Each access takes its timing from the configuration in force when the access is accepted. The memory behind the block is a behavioural array whose contents are computed from the address.

Top module: `flash_wait_ctrl`

## Requirements
- R1: After reset the control word reads 0x0000_0030: wait-state code 0, half-cycle off, prefetch enable (bit 4) set and prefetch status (bit 5) set.
- R2: A write updates the wait-state code in bits 2:0, the half-cycle enable in bit 3 and the prefetch enable in bit 4, and these read back at the same positions.
- R3: Bit 5 (prefetch status) is read-only, and writing 0 or 1 to it has no effect on the value read.
- R4: Bits 31:6 always read as zero, whatever is written.
- R5: The prefetch status bit takes the value of the prefetch enable one cycle after the enable changes, and it updates only in cycles with no access in progress. While an access is outstanding it holds.
- R6: With half-cycle off, a request presented in cycle c with code 0, 1 or 2 produces rd_valid for exactly one cycle, in cycle c+1, c+2 or c+3 respectively.
- R7: Codes 3 to 7 behave as two wait states (rd_valid in cycle c+3).
- R8: With half-cycle on and code 0, rd_valid and the data appear in the same cycle as the request. With a non-zero code, half-cycle has no effect on latency.
- R9: A request is accepted only while rd_ready is high. rd_ready is low from the cycle after acceptance until the valid cycle has passed, and requests or address changes during that time are ignored.
- R10: The returned word for address a is ((a zero-extended to 32 bits) * 0x01010101) XOR 0x5A5AC3C3, and belongs to the address of the accepted request.
- R11: A control write made while an access is outstanding does not change that access's latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Control word read data |
| rd_req | input | 1 | Memory read request |
| rd_addr | input | 4 | Memory read word address |
| rd_ready | output | 1 | High when a request can be accepted |
| rd_valid | output | 1 | One-cycle strobe marking returned data |
| rd_data | output | 32 | Returned memory word, zero when not valid |

## Verification
The bench sweeps every wait-state code against both half-cycle settings and every address, and measures the exact cycle of the valid strobe. An off-by-one counter would shift the strobe by a cycle. Unclamped codes 3 to 7 would stretch accesses past three cycles, and a half-cycle path that ignored the code would return early data at one or two wait states. It writes ones and zeros into the status and reserved bits: a writable status bit or stored reserved bits would show up in the read value. It toggles the prefetch enable both while idle and during a long access, which catches a status bit that updates at once or updates mid-access. It also changes the address and the wait-state code during an access, which catches a design that re-latches the address or reloads its counter.

// File: rtl/flwc_pkg.sv
package flwc_pkg;

  localparam int CFG_W       = 32;
  localparam int WORD_W      = 32;
  localparam int CODE_W      = 3;
  localparam int POS_HALF    = 3;
  localparam int POS_PF_EN   = 4;
  localparam int POS_PF_STAT = 5;
  localparam int USED_BITS   = 6;

  localparam logic [WORD_W-1:0] WORD_SPREAD = 32'h0101_0101;
  localparam logic [WORD_W-1:0] WORD_SALT   = 32'h5A5A_C3C3;

  typedef struct packed {
    logic              pf_en;
    logic              half;
    logic [CODE_W-1:0] code;
  } ctl_fields_t;

  function automatic logic [WORD_W-1:0] word_at(input int unsigned a);
    logic [WORD_W-1:0] ext;
    ext = WORD_W'(a);
    return (ext * WORD_SPREAD) ^ WORD_SALT;
  endfunction

endpackage

// File: rtl/flwc_rst_sync.sv
module flwc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_n;

  always_comb begin
    chain_n = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_n;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/flwc_cfg_reg.sv
module flwc_cfg_reg
  import flwc_pkg::*;
#(
  parameter int WS_MAX = 2,
  localparam int CNT_W = $clog2(WS_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wdata,
  input  logic             busy,
  output logic [CFG_W-1:0] rdata,
  output logic [CNT_W-1:0] ws_eff,
  output logic             half_en
);

  ctl_fields_t ctl_q, ctl_n;
  logic        pfs_q, pfs_n;

  // next state of the writable fields
  always_comb begin
    ctl_n = ctl_q;
    if (wr_en) begin
      ctl_n.code  = wdata[CODE_W-1:0];
      ctl_n.half  = wdata[POS_HALF];
      ctl_n.pf_en = wdata[POS_PF_EN];
    end
  end

  // status follows enable only between accesses
  always_comb begin
    pfs_n = busy ? pfs_q : ctl_q.pf_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q.code  <= '0;
      ctl_q.half  <= 1'b0;
      ctl_q.pf_en <= 1'b1;
      pfs_q       <= 1'b1;
    end else begin
      ctl_q <= ctl_n;
      pfs_q <= pfs_n;
    end
  end

  // read image
  always_comb begin
    rdata                = '0;
    rdata[CODE_W-1:0]    = ctl_q.code;
    rdata[POS_HALF]      = ctl_q.half;
    rdata[POS_PF_EN]     = ctl_q.pf_en;
    rdata[POS_PF_STAT]   = pfs_q;
  end

  // clamp of the encoded wait-state field
  always_comb begin
    if (int'(ctl_q.code) > WS_MAX) begin
      ws_eff = CNT_W'(WS_MAX);
    end else begin
      ws_eff = CNT_W'(ctl_q.code);
    end
  end

  assign half_en = ctl_q.half;

  assert_status_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> (pfs_q == $past(ctl_q.pf_en)));

  assert_status_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(pfs_q));

  assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[CFG_W-1:USED_BITS] == '0);

  assert_ws_clamped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(ws_eff) <= WS_MAX));

endmodule

// File: rtl/flwc_seq.sv
module flwc_seq #(
  parameter int AW     = 4,
  parameter int WS_MAX = 2,
  localparam int CNT_W = $clog2(WS_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [AW-1:0]    addr,
  input  logic [CNT_W-1:0] ws_eff,
  input  logic             half_en,
  output logic             ready,
  output logic             valid,
  output logic             busy,
  output logic [AW-1:0]    sel_addr
);

  logic             busy_q, busy_n;
  logic             vld_q, vld_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [AW-1:0]    addr_q, addr_n;
  logic             fast;
  logic             take;

  assign fast  = half_en && (ws_eff == '0);
  assign ready = !busy_q && !vld_q;
  assign take  = ready && req;

  always_comb begin
    busy_n = busy_q;
    cnt_n  = cnt_q;
    addr_n = addr_q;
    vld_n  = 1'b0;
    if (busy_q) begin
      if (cnt_q == CNT_W'(1)) begin
        busy_n = 1'b0;
        vld_n  = 1'b1;
      end else begin
        cnt_n = cnt_q - CNT_W'(1);
      end
    end else if (take && !fast) begin
      addr_n = addr;
      if (ws_eff == '0) begin
        vld_n = 1'b1;
      end else begin
        busy_n = 1'b1;
        cnt_n  = ws_eff;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      vld_q  <= 1'b0;
      cnt_q  <= '0;
      addr_q <= '0;
    end else begin
      busy_q <= busy_n;
      vld_q  <= vld_n;
      cnt_q  <= cnt_n;
      addr_q <= addr_n;
    end
  end

  assign valid    = vld_q || (take && fast);
  assign sel_addr = vld_q ? addr_q : addr;
  assign busy     = busy_q;

  assert_cnt_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q != '0) && (int'(cnt_q) <= WS_MAX));

  assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);

  assert_hold_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != CNT_W'(1)) |=> (busy_q && $stable(addr_q)));

  assert_no_ready_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !ready);

endmodule

// File: rtl/flwc_mem.sv
module flwc_mem
  import flwc_pkg::*;
#(
  parameter int AW = 4,
  localparam int DEPTH = 1 << AW
) (
  input  logic [AW-1:0]     addr,
  output logic [WORD_W-1:0] data
);

  logic [WORD_W-1:0] cells [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    assign cells[i] = word_at(i);
  end

  assign data = cells[addr];

endmodule

// File: rtl/flash_wait_ctrl.sv
module flash_wait_ctrl
  import flwc_pkg::*;
#(
  parameter int AW     = 4,
  parameter int WS_MAX = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic              rd_req,
  input  logic [AW-1:0]     rd_addr,
  output logic              rd_ready,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data
);

  localparam int CNT_W = $clog2(WS_MAX + 1);

  logic             rst_n_i;
  logic             busy;
  logic [CNT_W-1:0] ws_eff;
  logic             half_en;
  logic [AW-1:0]    sel_addr;
  logic [WORD_W-1:0] mem_word;

  flwc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  flwc_cfg_reg #(.WS_MAX(WS_MAX)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .wr_en   (cfg_wr_en),
    .wdata   (cfg_wdata),
    .busy    (busy),
    .rdata   (cfg_rdata),
    .ws_eff  (ws_eff),
    .half_en (half_en)
  );

  flwc_seq #(.AW(AW), .WS_MAX(WS_MAX)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .req      (rd_req),
    .addr     (rd_addr),
    .ws_eff   (ws_eff),
    .half_en  (half_en),
    .ready    (rd_ready),
    .valid    (rd_valid),
    .busy     (busy),
    .sel_addr (sel_addr)
  );

  flwc_mem #(.AW(AW)) u_mem (
    .addr (sel_addr),
    .data (mem_word)
  );

  assign rd_data = rd_valid ? mem_word : '0;

  assert_fast_path_R8: assert property (@(posedge clk) disable iff (!rst_n_i)
    (rd_valid && !$past(rd_valid) && !$past(busy) && $past(rd_ready) && rd_ready)
      |-> (half_en && ws_eff == '0));

  assert_data_gated_R10: assert property (@(posedge clk) disable iff (!rst_n_i)
    !rd_valid |-> (rd_data == '0));

endmodule

// File: tb/sim_flash_wait_ctrl.sv
module sim_flash_wait_ctrl;

  localparam int AW = 4;

  logic        clk;
  logic        rst_n;
  logic        cfg_wr_en;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        rd_req;
  logic [AW-1:0] rd_addr;
  logic        rd_ready;
  logic        rd_valid;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  flash_wait_ctrl #(.AW(AW), .WS_MAX(2)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr_en (cfg_wr_en),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .rd_req    (rd_req),
    .rd_addr   (rd_addr),
    .rd_ready  (rd_ready),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] exp_word(input int a);
    return ((32'(a)) * 32'h0101_0101) ^ 32'h5A5A_C3C3;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1;
    cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    #1;
  endtask

  // issues one request and returns the cycle index of the strobe (-1 if none)
  task automatic access(input int a, input string req, output int lat, output int extra);
    @(negedge clk);
    rd_req  = 1'b1;
    rd_addr = AW'(a);
    lat = -1;
    extra = 0;
    #1;
    for (int k = 0; k < 7; k++) begin
      if (k > 0) begin
        @(negedge clk);
        rd_req = 1'b0;
        #1;
      end
      if (rd_valid) begin
        if (lat < 0) begin
          lat = k;
          chk(rd_data == exp_word(a), "R10", rd_data, exp_word(a));
        end else begin
          extra++;
        end
      end
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int lat;
    int extra;
    cfg_wr_en = 1'b0;
    cfg_wdata = '0;
    rd_req    = 1'b0;
    rd_addr   = '0;
    rst_n     = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;

    // R1: reset image
    chk(cfg_rdata == 32'h0000_0030, "R1", cfg_rdata, 32'h30);
    chk(rd_ready == 1'b1 && rd_valid == 1'b0, "R1", {30'b0, rd_ready, rd_valid}, 32'h2);

    // R2: writable fields
    wr(32'h0000_001A);
    chk(cfg_rdata[4:0] == 5'h1A, "R2", cfg_rdata, 32'h1A);
    wr(32'h0000_0005);
    chk(cfg_rdata[4:0] == 5'h05, "R2", cfg_rdata, 32'h05);

    // R5: status follows one cycle later (enable dropped by previous write)
    wr(32'h0000_0010);
    chk(cfg_rdata[5] == 1'b0, "R5", cfg_rdata, 32'h0);
    @(negedge clk); #1;
    chk(cfg_rdata[5] == 1'b1, "R5", cfg_rdata, 32'h30);
    wr(32'h0000_0000);
    chk(cfg_rdata[5] == 1'b1, "R5", cfg_rdata, 32'h20);
    @(negedge clk); #1;
    chk(cfg_rdata[5] == 1'b0, "R5", cfg_rdata, 32'h0);

    // R3: status bit ignores writes of 1 and of 0
    wr(32'h0000_0020);
    @(negedge clk); #1;
    chk(cfg_rdata == 32'h0000_0000, "R3", cfg_rdata, 32'h0);
    wr(32'h0000_0010);
    @(negedge clk); #1;
    wr(32'h0000_0010 & ~32'h20);
    @(negedge clk); #1;
    chk(cfg_rdata == 32'h0000_0030, "R3", cfg_rdata, 32'h30);

    // R4: reserved bits
    wr(32'hFFFF_FFC0);
    chk(cfg_rdata[31:6] == '0, "R4", cfg_rdata, 32'h20);
    wr(32'hFFFF_FFFF);
    @(negedge clk); #1;
    chk(cfg_rdata == 32'h0000_003F, "R4", cfg_rdata, 32'h3F);

    // R6 R7 R8 R10: sweep of codes, half-cycle and addresses
    for (int code = 0; code < 8; code++) begin
      for (int h = 0; h < 2; h++) begin
        wr(32'(code) | (32'(h) << 3) | 32'h10);
        for (int a = 0; a < 16; a++) begin
          int e;
          e = (h == 1 && code == 0) ? 0 : ((code > 2) ? 2 : code) + 1;
          access(a, (code > 2) ? "R7" : ((h == 1) ? "R8" : "R6"), lat, extra);
          if (code > 2)
            chk(lat == e, "R7", 32'(lat), 32'(e));
          else if (h == 1)
            chk(lat == e, "R8", 32'(lat), 32'(e));
          else
            chk(lat == e, "R6", 32'(lat), 32'(e));
          chk(extra == 0, "R6", 32'(extra), 32'h0);
        end
      end
    end

    // R9 and R11: address change, extra request and config write while busy
    wr(32'h0000_0012);
    @(negedge clk);
    rd_req = 1'b1;
    rd_addr = AW'(3);
    #1;
    chk(rd_ready == 1'b1, "R9", {31'b0, rd_ready}, 32'h1);
    @(negedge clk);
    rd_addr = AW'(9);
    cfg_wr_en = 1'b1;
    cfg_wdata = 32'h0000_0000;
    #1;
    chk(rd_ready == 1'b0 && rd_valid == 1'b0, "R9", {30'b0, rd_ready, rd_valid}, 32'h0);
    @(negedge clk);
    cfg_wr_en = 1'b0;
    rd_req = 1'b0;
    #1;
    chk(rd_valid == 1'b0, "R11", {31'b0, rd_valid}, 32'h0);
    chk(cfg_rdata[5] == 1'b1, "R5", cfg_rdata, 32'h20);
    @(negedge clk); #1;
    chk(rd_valid == 1'b1, "R11", {31'b0, rd_valid}, 32'h1);
    chk(rd_data == exp_word(3), "R9", rd_data, exp_word(3));
    @(negedge clk); #1;
    chk(rd_valid == 1'b0, "R9", {31'b0, rd_valid}, 32'h0);
    chk(cfg_rdata[5] == 1'b0, "R5", cfg_rdata, 32'h0);
    @(negedge clk); #1;
    chk(rd_valid == 1'b0, "R9", {31'b0, rd_valid}, 32'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule